// File: doc/BRIEF.md
# Sticky Interrupt Status Aggregator

This block collects interrupt events from a serial peripheral's FIFO and transfer logic and presents them to a processor as one level-sensitive interrupt line. Three software-visible registers control it: a master enable word, a sticky status word and a per-source enable word. Hardware events set status bits, and those bits hold until software changes them. The interrupt line is raised when at least one status bit is set whose enable bit is also set, and the master enable is on.

Software changes status bits by writing a mask that is XORed into the stored value, so a write of 1 inverts a bit rather than only clearing it. Two receive-side bits follow live FIFO levels. While their level input is high they are set again on every cycle, even straight after software cleared them. The event sources are outside this block. They arrive as single-cycle pulses (transfer complete, overrun, transmit half-empty, underrun) or as held levels (receive FIFO non-empty, receive FIFO full). Register writes take effect in one cycle. Reads are combinational and have no side effects.

Top module: `irq_aggr_top`

## Requirements
- R1: While reset is high and in the cycle after it, the master enable, status and per-source enable registers read zero, and `irq_o` is low.
- R2: The master enable register is at byte offset 0x1C. Only bit 31 is stored. It reads back as 0x8000_0000 when set, and every other bit reads 0.
- R3: The per-source enable register is at byte offset 0x28. Only the implemented source bits (mask 0x17C) are stored, and other bits read 0.
- R4: The status register is at byte offset 0x20. A write XORs the written value, masked to 0x17C, into the stored bits. Bits outside the mask read 0.
- R5: Status bit positions are as follows. Bit 2 is transmit-data-empty and bit 8 is receive-not-empty, and a transfer-complete pulse sets both. Bit 5 is receive overrun, bit 6 is transmit half-empty and bit 3 is transmit underrun, each set by its own pulse. A set bit stays set until a status write inverts it.
- R6: While `lvl_rx_nonempty` is high, bit 8 is set on every cycle. While `lvl_rx_full` is high, bit 4 is set on every cycle. This holds in the same cycle as a software write that would clear the bit.
- R7: When a hardware set and a status-write toggle hit the same bit in the same cycle, the bit ends up set.
- R8: `irq_o` is a register. One cycle after any register change it equals (status AND per-source enable is non-zero) AND master-enable bit 31.
- R9: A write with `wr_en` low, or a write to an offset other than 0x1C, 0x20 or 0x28, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| ev_xfer_done | input | 1 | Pulse: one byte transfer completed |
| ev_rx_overrun | input | 1 | Pulse: received byte dropped |
| ev_tx_half_empty | input | 1 | Pulse: transmit FIFO reached half empty |
| ev_tx_underrun | input | 1 | Pulse: transmit FIFO underrun |
| lvl_rx_nonempty | input | 1 | Level: receive FIFO holds data |
| lvl_rx_full | input | 1 | Level: receive FIFO is full |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A status-register toggle write can land in the same cycle as a hardware set of the same bit, either from an event pulse or from a held receive level. The bench provokes this in two ways: it writes an inverting mask while pulsing the underrun and transfer-complete events, and it writes a clearing mask while the receive-not-empty level is held high. A behavioural model applies "toggle, then OR in the sets" and decides the result, and the read-back status and the interrupt line are compared against that model on every clock.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

    // Width of the stored status / per-source enable field (highest source bit + 1).
    localparam int STAT_W = 9;

    // Source bit positions; software decodes these, so they are fixed.
    localparam int B_TX_EMPTY     = 2;
    localparam int B_TX_UNDERRUN  = 3;
    localparam int B_RX_FULL      = 4;
    localparam int B_RX_OVERRUN   = 5;
    localparam int B_TX_HALF      = 6;
    localparam int B_RX_NONEMPTY  = 8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_GIE  = 2'd1,
        SEL_ISR  = 2'd2,
        SEL_IER  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic xfer_done;
        logic rx_overrun;
        logic tx_half_empty;
        logic tx_underrun;
    } pulse_evt_t;

    typedef struct packed {
        logic rx_nonempty;
        logic rx_full;
    } level_evt_t;

    function automatic logic [STAT_W-1:0] impl_mask();
        logic [STAT_W-1:0] m;
        m = '0;
        m[B_TX_EMPTY]    = 1'b1;
        m[B_TX_UNDERRUN] = 1'b1;
        m[B_RX_FULL]     = 1'b1;
        m[B_RX_OVERRUN]  = 1'b1;
        m[B_TX_HALF]     = 1'b1;
        m[B_RX_NONEMPTY] = 1'b1;
        return m;
    endfunction

    function automatic logic [STAT_W-1:0] set_vector(pulse_evt_t p, level_evt_t l);
        logic [STAT_W-1:0] s;
        s = '0;
        s[B_TX_EMPTY]    = p.xfer_done;
        s[B_RX_NONEMPTY] = p.xfer_done | l.rx_nonempty;
        s[B_RX_OVERRUN]  = p.rx_overrun;
        s[B_TX_HALF]     = p.tx_half_empty;
        s[B_TX_UNDERRUN] = p.tx_underrun;
        s[B_RX_FULL]     = l.rx_full;
        return s;
    endfunction

endpackage

// File: rtl/irq_aggr_decode.sv
module irq_aggr_decode
    import irq_aggr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] GIE_OFS = 8'h1C,
    parameter logic [ADDR_W-1:0] ISR_OFS = 8'h20,
    parameter logic [ADDR_W-1:0] IER_OFS = 8'h28
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        sel = SEL_NONE;
        if (valid) begin
            if (addr == GIE_OFS)      sel = SEL_GIE;
            else if (addr == ISR_OFS) sel = SEL_ISR;
            else if (addr == IER_OFS) sel = SEL_IER;
        end
    end
endmodule

// File: rtl/irq_aggr_status.sv
module irq_aggr_status
    import irq_aggr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              toggle_en,
    input  logic [STAT_W-1:0] toggle_bits,
    input  logic [STAT_W-1:0] set_bits,
    output logic [STAT_W-1:0] status_q
);
    logic [STAT_W-1:0] flip;
    logic [STAT_W-1:0] status_d;

    always_comb begin
        flip     = toggle_en ? (toggle_bits & impl_mask()) : '0;
        // Hardware sets are applied after the toggle, so a set always wins.
        status_d = ((status_q ^ flip) | set_bits) & impl_mask();
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end
endmodule

// File: rtl/irq_aggr_cfg_reg.sv
module irq_aggr_cfg_reg #(
    parameter int W = 1,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d & KEEP;
    end
endmodule

// File: rtl/irq_aggr_line.sv
module irq_aggr_line
    import irq_aggr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] status,
    input  logic [STAT_W-1:0] enables,
    input  logic              master_en,
    output logic              irq_q
);
    logic pending;

    always_comb pending = (|(status & enables)) & master_en;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= pending;
    end
endmodule

// File: rtl/irq_aggr_top.sv
module irq_aggr_top
    import irq_aggr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] GIE_OFS = 8'h1C,
    parameter logic [ADDR_W-1:0] ISR_OFS = 8'h20,
    parameter logic [ADDR_W-1:0] IER_OFS = 8'h28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ev_xfer_done,
    input  logic              ev_rx_overrun,
    input  logic              ev_tx_half_empty,
    input  logic              ev_tx_underrun,
    input  logic              lvl_rx_nonempty,
    input  logic              lvl_rx_full,
    output logic              irq_o
);
    localparam int GIE_BIT = DATA_W - 1;
    localparam int PAD_W   = DATA_W - STAT_W;

    reg_sel_e          wr_sel;
    reg_sel_e          rd_sel;
    pulse_evt_t        pulses;
    level_evt_t        levels;
    logic [STAT_W-1:0] hw_set;
    logic [STAT_W-1:0] isr_q;
    logic [STAT_W-1:0] ier_q;
    logic              gie_q;
    logic              st_wr;

    irq_aggr_decode #(
        .ADDR_W(ADDR_W), .GIE_OFS(GIE_OFS), .ISR_OFS(ISR_OFS), .IER_OFS(IER_OFS)
    ) u_wr_dec (
        .valid (wr_en),
        .addr  (wr_addr),
        .sel   (wr_sel)
    );

    irq_aggr_decode #(
        .ADDR_W(ADDR_W), .GIE_OFS(GIE_OFS), .ISR_OFS(ISR_OFS), .IER_OFS(IER_OFS)
    ) u_rd_dec (
        .valid (1'b1),
        .addr  (rd_addr),
        .sel   (rd_sel)
    );

    always_comb begin
        pulses = '{xfer_done:     ev_xfer_done,
                   rx_overrun:    ev_rx_overrun,
                   tx_half_empty: ev_tx_half_empty,
                   tx_underrun:   ev_tx_underrun};
        levels = '{rx_nonempty: lvl_rx_nonempty,
                   rx_full:     lvl_rx_full};
        hw_set = set_vector(pulses, levels);
        st_wr  = (wr_sel == SEL_ISR);
    end

    irq_aggr_status u_status (
        .clk         (clk),
        .rst         (rst),
        .toggle_en   (st_wr),
        .toggle_bits (wr_data[STAT_W-1:0]),
        .set_bits    (hw_set),
        .status_q    (isr_q)
    );

    irq_aggr_cfg_reg #(.W(STAT_W), .KEEP(impl_mask())) u_ier (
        .clk  (clk),
        .rst  (rst),
        .load (wr_sel == SEL_IER),
        .d    (wr_data[STAT_W-1:0]),
        .q    (ier_q)
    );

    irq_aggr_cfg_reg #(.W(1), .KEEP(1'b1)) u_gie (
        .clk  (clk),
        .rst  (rst),
        .load (wr_sel == SEL_GIE),
        .d    (wr_data[GIE_BIT]),
        .q    (gie_q)
    );

    irq_aggr_line u_line (
        .clk       (clk),
        .rst       (rst),
        .status    (isr_q),
        .enables   (ier_q),
        .master_en (gie_q),
        .irq_q     (irq_o)
    );

    always_comb begin
        unique case (rd_sel)
            SEL_GIE: rd_data = {gie_q, {(DATA_W-1){1'b0}}};
            SEL_ISR: rd_data = {{PAD_W{1'b0}}, isr_q};
            SEL_IER: rd_data = {{PAD_W{1'b0}}, ier_q};
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk
    import irq_aggr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              st_wr,
    input logic              ev_xfer_done,
    input logic              ev_tx_underrun,
    input logic              lvl_rx_nonempty,
    input logic              lvl_rx_full,
    input logic [STAT_W-1:0] isr_q,
    input logic [STAT_W-1:0] ier_q,
    input logic              gie_q,
    input logic              irq_o
);
    logic rst_seen_q = 1'b0;
    logic pv_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        pv_q       <= !rst;
    end

    always @(negedge clk) begin
        if (rst_seen_q) begin
            AST_RESET_QUIET: assert (!irq_o && isr_q == '0 && ier_q == '0 && !gie_q); // R1
        end
    end

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        pv_q |-> (irq_o == $past((|(isr_q & ier_q)) && gie_q))); // R8

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !st_wr |=> ((isr_q & $past(isr_q)) == $past(isr_q))); // R5

    AST_RXNE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        lvl_rx_nonempty |=> isr_q[B_RX_NONEMPTY]); // R6

    AST_RXFULL_LEVEL: assert property (@(posedge clk) disable iff (rst)
        lvl_rx_full |=> isr_q[B_RX_FULL]); // R6

    AST_XFER_SETS: assert property (@(posedge clk) disable iff (rst)
        ev_xfer_done |=> (isr_q[B_TX_EMPTY] && isr_q[B_RX_NONEMPTY])); // R7

    AST_UNDERRUN_SETS: assert property (@(posedge clk) disable iff (rst)
        ev_tx_underrun |=> isr_q[B_TX_UNDERRUN]); // R7
endmodule

bind irq_aggr_top irq_aggr_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .st_wr           (st_wr),
    .ev_xfer_done    (ev_xfer_done),
    .ev_tx_underrun  (ev_tx_underrun),
    .lvl_rx_nonempty (lvl_rx_nonempty),
    .lvl_rx_full     (lvl_rx_full),
    .isr_q           (isr_q),
    .ier_q           (ier_q),
    .gie_q           (gie_q),
    .irq_o           (irq_o)
);

// File: tb/irq_aggr_top_tb_top.sv
`timescale 1ns/1ps
module irq_aggr_top_tb_top;
    localparam int MASK = 32'h0000_017C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [31:0] wr_data = 32'h0;
    logic [7:0]  rd_addr = 8'h20;
    logic [31:0] rd_data;
    logic        ev_xfer_done = 1'b0, ev_rx_overrun = 1'b0;
    logic        ev_tx_half_empty = 1'b0, ev_tx_underrun = 1'b0;
    logic        lvl_rx_nonempty = 1'b0, lvl_rx_full = 1'b0;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string tag = "R1";

    // behavioural reference state
    int unsigned m_isr = 0, m_ier = 0, m_gie = 0;
    bit m_irq = 0;

    always #2.5 clk = ~clk;

    irq_aggr_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_xfer_done(ev_xfer_done), .ev_rx_overrun(ev_rx_overrun),
        .ev_tx_half_empty(ev_tx_half_empty), .ev_tx_underrun(ev_tx_underrun),
        .lvl_rx_nonempty(lvl_rx_nonempty), .lvl_rx_full(lvl_rx_full),
        .irq_o(irq_o)
    );

    function automatic int unsigned model_read(logic [7:0] a);
        if (a == 8'h1C) return m_gie;
        if (a == 8'h20) return m_isr;
        if (a == 8'h28) return m_ier;
        return 0;
    endfunction

    task automatic check(string what, int unsigned act, int unsigned exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    // One clock: update the model from the inputs, pass the edge, compare, release pulses.
    task automatic tick();
        int unsigned n_isr, n_ier, n_gie, sets;
        bit n_irq;
        if (rst) begin
            n_isr = 0; n_ier = 0; n_gie = 0; n_irq = 0;
        end else begin
            sets = 0;
            if (ev_xfer_done)     sets |= (1 << 2) | (1 << 8);
            if (lvl_rx_nonempty)  sets |= (1 << 8);
            if (ev_rx_overrun)    sets |= (1 << 5);
            if (ev_tx_half_empty) sets |= (1 << 6);
            if (ev_tx_underrun)   sets |= (1 << 3);
            if (lvl_rx_full)      sets |= (1 << 4);
            n_irq = ((m_isr & m_ier) != 0) && (m_gie[31]);
            n_isr = m_isr;
            n_ier = m_ier;
            n_gie = m_gie;
            if (wr_en && wr_addr == 8'h20) n_isr = n_isr ^ (wr_data & MASK);
            if (wr_en && wr_addr == 8'h28) n_ier = wr_data & MASK;
            if (wr_en && wr_addr == 8'h1C) n_gie = wr_data & 32'h8000_0000;
            n_isr = n_isr | sets;
        end
        @(posedge clk);
        #1;
        m_isr = n_isr; m_ier = n_ier; m_gie = n_gie; m_irq = n_irq;
        check("irq_o", irq_o, m_irq);
        check($sformatf("rd[%02h]", rd_addr), rd_data, model_read(rd_addr));
        wr_en = 0;
        ev_xfer_done = 0; ev_rx_overrun = 0; ev_tx_half_empty = 0; ev_tx_underrun = 0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
    endtask

    task automatic expect_reg(logic [7:0] a, int unsigned exp);
        rd_addr = a;
        #0.5;
        check($sformatf("direct rd[%02h]", a), rd_data, exp);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        tag = "R1";
        tick(); tick();
        rst = 0;
        tick();
        expect_reg(8'h1C, 0); expect_reg(8'h20, 0); expect_reg(8'h28, 0);
        check("irq after reset", irq_o, 0);

        // R2: master enable stores bit 31 only
        tag = "R2";
        rd_addr = 8'h1C;
        wr(8'h1C, 32'hFFFF_FFFF);
        expect_reg(8'h1C, 32'h8000_0000);
        wr(8'h1C, 32'h7FFF_FFFF);
        expect_reg(8'h1C, 32'h0);

        // R3: per-source enable masked to 0x17C
        tag = "R3";
        rd_addr = 8'h28;
        wr(8'h28, 32'hFFFF_FFFF);
        expect_reg(8'h28, 32'h17C);
        wr(8'h28, 32'h0000_0000);

        // R5: each pulse sets its own bit and it sticks
        tag = "R5";
        rd_addr = 8'h20;
        ev_xfer_done = 1; tick();
        expect_reg(8'h20, 32'h104);
        ev_rx_overrun = 1; tick();
        ev_tx_half_empty = 1; tick();
        ev_tx_underrun = 1; tick();
        tick(); tick();
        expect_reg(8'h20, 32'h16C);

        // R4: XOR writes invert bits; unimplemented bits ignored
        tag = "R4";
        rd_addr = 8'h20;
        wr(8'h20, 32'hFFFF_FFFF);
        expect_reg(8'h20, 32'h010);
        wr(8'h20, 32'h0000_0110);
        expect_reg(8'h20, 32'h100);
        wr(8'h20, 32'h0000_0100);
        expect_reg(8'h20, 32'h0);

        // R8: registered interrupt line
        tag = "R8";
        wr(8'h28, 32'h0000_0020);
        ev_rx_overrun = 1; tick();
        check("irq masked by master enable", irq_o, 0);
        wr(8'h1C, 32'h8000_0000);
        tick();
        check("irq raised", irq_o, 1);
        wr(8'h1C, 32'h0);
        tick();
        check("irq dropped", irq_o, 0);
        wr(8'h1C, 32'h8000_0000);
        wr(8'h20, 32'h0000_0020);
        tick();
        check("irq after clear", irq_o, 0);
        wr(8'h28, 32'h0000_0000);

        // R6: levels reassert over a clearing write
        tag = "R6";
        rd_addr = 8'h20;
        lvl_rx_nonempty = 1; lvl_rx_full = 1;
        tick();
        expect_reg(8'h20, 32'h110);
        wr(8'h20, 32'h0000_0110);
        expect_reg(8'h20, 32'h110);
        lvl_rx_nonempty = 0; lvl_rx_full = 0;
        wr(8'h20, 32'h0000_0110);
        expect_reg(8'h20, 32'h0);

        // R7: set and toggle in the same cycle -> set
        tag = "R7";
        ev_tx_underrun = 1; tick();
        ev_tx_underrun = 1; wr(8'h20, 32'h0000_0008);
        expect_reg(8'h20, 32'h008);
        ev_xfer_done = 1; wr(8'h20, 32'h0000_0104);
        expect_reg(8'h20, 32'h10C);

        // R9: writes ignored when strobe low or offset unmapped
        tag = "R9";
        wr_en = 0; wr_addr = 8'h20; wr_data = 32'hFFFF_FFFF; tick();
        expect_reg(8'h20, 32'h10C);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF);
        expect_reg(8'h20, 32'h10C);
        expect_reg(8'h28, 32'h0);
        expect_reg(8'h1C, 32'h8000_0000);

        // R1: reset mid-run clears everything
        tag = "R1";
        rst = 1; tick(); rst = 0; tick();
        expect_reg(8'h20, 0);
        expect_reg(8'h1C, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule